// File: doc/BRIEF.md
# Flash Module Control Register File

This block sits between a 16-bit processor bus and an embedded flash array. It keeps the registers that steer array operations. It also decides what a bus access means, based on a one-bit view selector. In the array view, which is the view after reset, reads return array data in the same cycle. A bus write in the array view does not change the array. It captures the bus address and the bus data into the latched-address and latched-data registers, which are later used by a program pulse.

In the register view, the low two address bits pick one of four registers, and the same group of four appears again across the whole module address range. The four registers are segment control, test, write address and write data. The segment-control register is decoded into the array command outputs: eight segment enables, a two-bit operation field, a read/verify mode and an execute strobe. While the execute bit is set, the segment enables cannot be changed. The view selector has its own select line. It can be written but not read back.

Top module: `flash_ctl_regfile`

## Requirements
- R1: After reset the view is the array view, all four registers hold zero, and every command output is zero.
- R2: A write with `modeSel` high sets the view from `busWrData[0]`: 0 selects the register view and 1 selects the array view. A read with `modeSel` high returns 0000h.
- R3: In the register view, `busAddr[1:0]` picks the register. 0 is segment control, 1 is test, 2 is write address and 3 is write data. The higher address bits are ignored, so the group repeats across the range. A write is visible on the next read from any alias.
- R4: In the array view, a read returns `arrRdData` in the same cycle. `arrAddr` always follows `busAddr`.
- R5: In the array view, a bus write stores `busAddr` into the write-address register and `busWrData` into the write-data register. Segment control and test stay unchanged.
- R6: A write to segment control while its bit 0 (execute) is 1 leaves bits 15:8 unchanged. The other bits of that write still take effect.
- R7: `segEn` equals segment-control bits 15:8, in any combination. `execOn` equals bit 0. `opCode` equals bits 2:1, where 01 means erase and 10 means flash-write.
- R8: Segment-control bits 4:3 select the read level on `vfyMode`. 00 gives standard read (`vfyMode` 00). Bit 3 alone gives verify-zeros (01). Bit 4 alone gives verify-ones (10). Both bits, as in the command word 0018h, give inverse-erase read (11).
- R9: The write-address register is ADDR_W bits wide, 14 by default. A register-view write keeps the low ADDR_W data bits, and a read returns them zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Bus word address within the module |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busWrData | input | 16 | Bus write data |
| modeSel | input | 1 | Selects the view-selector register for this access |
| busRdData | output | 16 | Bus read data, combinational |
| arrAddr | output | ADDR_W | Read address to the array |
| arrRdData | input | 16 | Data returned by the array |
| segEn | output | 8 | Per-segment enables |
| opCode | output | 2 | Operation field |
| vfyMode | output | 2 | Read level select |
| execOn | output | 1 | Execute strobe |
| latchAddr | output | ADDR_W | Latched write address |
| latchData | output | 16 | Latched write data |

## Verification
Register writes go to addresses with different high bits, and each is read back through a different alias. A correct readback therefore shows both the offset decode and the repetition across the range. The data patterns include all-ones to the write-address register, which exposes truncation, and zero words. In the array view, array-stub data is read and array-side writes are made, and segment control is then read back in the register view. This separates latching from storing. Segment-control words are chosen to set the execute bit, change the enables while it is set, and then clear it. They also cover all four combinations of the verify bits, which tells the lock and the read-level decode apart.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_ARRAY,
    RD_SEG,
    RD_TEST,
    RD_WADDR,
    RD_WDATA
  } rdSel_e;

  typedef struct packed {
    logic   wrSeg;
    logic   wrTest;
    logic   wrAddr;
    logic   wrData;
    logic   latchArr;
    rdSel_e rdSel;
  } ctlStrobe_t;

  localparam int WORD_W = 16;
  localparam int SEG_LO = 8;
  localparam int NUM_SEG = 8;

endpackage

// File: rtl/flash_ctl_control.sv
module flash_ctl_control
  import flash_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regOfs,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic       modeWrBit,
  input  logic       modeSel,
  output ctlStrobe_t strb
);

  logic arrayView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) arrayView <= 1'b1;
    else if (busWrEn && modeSel) arrayView <= modeWrBit;
  end

  logic regWr;
  assign regWr = busWrEn && !modeSel && !arrayView;

  always_comb begin
    strb = '0;
    strb.rdSel    = RD_ZERO;
    strb.wrSeg    = regWr && (regOfs == 2'd0);
    strb.wrTest   = regWr && (regOfs == 2'd1);
    strb.wrAddr   = regWr && (regOfs == 2'd2);
    strb.wrData   = regWr && (regOfs == 2'd3);
    strb.latchArr = busWrEn && !modeSel && arrayView;
    if (busRdEn && !modeSel) begin
      if (arrayView) strb.rdSel = RD_ARRAY;
      else begin
        case (regOfs)
          2'd0:    strb.rdSel = RD_SEG;
          2'd1:    strb.rdSel = RD_TEST;
          2'd2:    strb.rdSel = RD_WADDR;
          default: strb.rdSel = RD_WDATA;
        endcase
      end
    end
  end

  // R2: the view changes only through a selector write
  a_r2_view_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && modeSel) |=> $stable(arrayView));

  // R5: array-view bus writes never reach the register strobes
  a_r5_no_reg_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchArr |-> !(strb.wrSeg || strb.wrTest || strb.wrAddr || strb.wrData));

  // R3: at most one write action per cycle
  a_r3_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSeg, strb.wrTest, strb.wrAddr, strb.wrData, strb.latchArr}));

endmodule

// File: rtl/flash_ctl_datapath.sv
module flash_ctl_datapath
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  input  logic [WORD_W-1:0] arrRdData,
  output logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] segCtl,
  output logic [ADDR_W-1:0] wAddrReg,
  output logic [WORD_W-1:0] wDataReg
);

  logic [WORD_W-1:0] testReg;
  logic [WORD_W-1:0] segNext;
  logic [WORD_W-1:0] wAddrWide;
  logic [ADDR_W-1:0] wAddrFromBus;

  generate
    if (ADDR_W < WORD_W) begin : g_pad
      assign wAddrWide    = {{(WORD_W-ADDR_W){1'b0}}, wAddrReg};
      assign wAddrFromBus = busWrData[ADDR_W-1:0];
    end else begin : g_full
      assign wAddrWide    = wAddrReg[WORD_W-1:0];
      assign wAddrFromBus = {{(ADDR_W-WORD_W){1'b0}}, busWrData};
    end
  endgenerate

  // Enables are frozen while a pulse is running
  always_comb begin
    segNext = busWrData;
    if (segCtl[0]) segNext[WORD_W-1:SEG_LO] = segCtl[WORD_W-1:SEG_LO];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segCtl   <= '0;
      testReg  <= '0;
      wAddrReg <= '0;
      wDataReg <= '0;
    end else begin
      if (strb.wrSeg)  segCtl  <= segNext;
      if (strb.wrTest) testReg <= busWrData;
      if (strb.wrAddr) wAddrReg <= wAddrFromBus;
      else if (strb.latchArr) wAddrReg <= busAddr;
      if (strb.wrData || strb.latchArr) wDataReg <= busWrData;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_ARRAY: rdData = arrRdData;
      RD_SEG:   rdData = segCtl;
      RD_TEST:  rdData = testReg;
      RD_WADDR: rdData = wAddrWide;
      RD_WDATA: rdData = wDataReg;
      default:  rdData = '0;
    endcase
  end

  // R6: enables keep their value across a write made while execute is set
  a_r6_seg_lock: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSeg && segCtl[0]) |=> $stable(segCtl[WORD_W-1:SEG_LO]));

  // R5: an array-view write captures the bus address and data
  a_r5_latch: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchArr |=> (wAddrReg == $past(busAddr)) && (wDataReg == $past(busWrData)));

  // R5: segment control changes only on its own strobe
  a_r5_seg_only_own: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrSeg |=> $stable(segCtl));

endmodule

// File: rtl/flash_ctl_regfile.sv
module flash_ctl_regfile
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [15:0]       busWrData,
  input  logic              modeSel,
  output logic [15:0]       busRdData,
  output logic [ADDR_W-1:0] arrAddr,
  input  logic [15:0]       arrRdData,
  output logic [7:0]        segEn,
  output logic [1:0]        opCode,
  output logic [1:0]        vfyMode,
  output logic              execOn,
  output logic [ADDR_W-1:0] latchAddr,
  output logic [15:0]       latchData
);

  ctlStrobe_t        strb;
  logic [WORD_W-1:0] segCtl;

  flash_ctl_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regOfs    (busAddr[1:0]),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .modeWrBit (busWrData[0]),
    .modeSel   (modeSel),
    .strb      (strb)
  );

  flash_ctl_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .arrRdData (arrRdData),
    .rdData    (busRdData),
    .segCtl    (segCtl),
    .wAddrReg  (latchAddr),
    .wDataReg  (latchData)
  );

  assign arrAddr = busAddr;
  assign segEn   = segCtl[WORD_W-1:SEG_LO];
  assign opCode  = segCtl[2:1];
  assign execOn  = segCtl[0];
  assign vfyMode = {segCtl[4], segCtl[3]};

  // R7: execute can rise only through a segment-control write
  a_r7_exec_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(execOn) |-> $past(busWrEn && !modeSel && busAddr[1:0] == 2'd0));

endmodule

// File: tb/tb_flash_ctl_regfile.sv
module tb_flash_ctl_regfile;

  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic [15:0]   busWrData = '0;
  logic          modeSel = 1'b0;
  logic [15:0]   busRdData;
  logic [AW-1:0] arrAddr;
  logic [15:0]   arrRdData;
  logic [7:0]    segEn;
  logic [1:0]    opCode;
  logic [1:0]    vfyMode;
  logic          execOn;
  logic [AW-1:0] latchAddr;
  logic [15:0]   latchData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  // array stub
  assign arrRdData = {2'b00, arrAddr} ^ 16'hA5C3;

  flash_ctl_regfile #(.ADDR_W(AW)) dut (.*);

  // {address, write data, expected readback}
  localparam logic [45:0] VEC [0:5] = '{
    {14'h0001, 16'h1234, 16'h1234},
    {14'h0006, 16'hFFFF, 16'h3FFF},
    {14'h3FFB, 16'hBEEF, 16'hBEEF},
    {14'h1000, 16'hA51E, 16'hA51E},
    {14'h2ABD, 16'h0000, 16'h0000},
    {14'h0004, 16'h0018, 16'h0018}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic sel);
    @(negedge clk);
    busAddr = a; busWrData = d; modeSel = sel; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; modeSel = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic sel, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; modeSel = sel; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0; modeSel = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 segEn", segEn, 0);
    chk("R1 exec", execOn, 0);
    chk("R1 latchData", latchData, 0);
    rstN = 1'b1;
    // R1 + R4: array view after reset
    rd(14'h0123, 1'b0, d);
    chk("R1 R4 array read", d, 16'h0123 ^ 16'hA5C3);
    // R2 selector reads zero
    rd(14'h0000, 1'b1, d);
    chk("R2 selector read", d, 16'h0000);
    // R5 array write latches
    wr(14'h2A5A, 16'h5AA5, 1'b0);
    chk("R5 latchAddr", latchAddr, 14'h2A5A);
    chk("R5 latchData", latchData, 16'h5AA5);
    chk("R5 segEn untouched", segEn, 0);
    // R2 switch to register view
    wr(14'h0000, 16'h0000, 1'b1);
    rd(14'h0000, 1'b0, d);
    chk("R5 segctl untouched", d, 16'h0000);
    rd(14'h0001, 1'b0, d);
    chk("R5 test untouched", d, 16'h0000);
    rd(14'h0003, 1'b0, d);
    chk("R2 register view wdata", d, 16'h5AA5);
    // R3 R9 table walk with aliased readback
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][45:32], VEC[i][31:16], 1'b0);
      rd(VEC[i][45:32] ^ 14'h0100, 1'b0, d);
      chk("R3 R9 alias readback", d, VEC[i][15:0]);
      if (i == 3) begin
        chk("R7 segEn", segEn, 8'hA5);
        chk("R7 opCode", opCode, 2'b11);
        chk("R8 vfy inverse", vfyMode, 2'b11);
        chk("R7 exec low", execOn, 0);
      end
    end
    chk("R8 0018h inverse", vfyMode, 2'b11);
    chk("R7 segEn cleared", segEn, 8'h00);
    // R6 execute lock
    wr(14'h0000, 16'hF00B, 1'b0);
    chk("R7 erase op", opCode, 2'b01);
    chk("R7 exec set", execOn, 1);
    chk("R8 verify zeros", vfyMode, 2'b01);
    chk("R7 segEn F0", segEn, 8'hF0);
    wr(14'h0000, 16'h0F12, 1'b0);
    chk("R6 locked enables", segEn, 8'hF0);
    chk("R6 exec cleared", execOn, 0);
    chk("R8 verify ones", vfyMode, 2'b10);
    wr(14'h0000, 16'h0F05, 1'b0);
    chk("R6 unlocked enables", segEn, 8'h0F);
    chk("R7 flash-write op", opCode, 2'b10);
    chk("R8 standard", vfyMode, 2'b00);
    // R2 back to array view, R4 read and address follow
    wr(14'h0000, 16'h0001, 1'b1);
    rd(14'h3FFF, 1'b0, d);
    chk("R4 array read", d, 16'h3FFF ^ 16'hA5C3);
    chk("R4 arrAddr", arrAddr, 14'h3FFF);
    wr(14'h0000, 16'h7777, 1'b0);
    chk("R5 latch at offset 0", latchData, 16'h7777);
    chk("R5 segEn kept", segEn, 8'h0F);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule